// File: doc/BRIEF.md
# Capture Window Cropper with 2:1 Downsizing

This block sits in a camera capture path, directly after the pixel input. It receives one pixel per clock while both a frame-valid and a line-valid qualifier are high. It counts the column and line of every pixel. From the whole sensor frame it forwards only a programmed rectangle, which is described by a left offset, a top offset, a width and a height. Each axis can also be halved on its own: every other column, every other line, or both. The output is a pixel stream carrying its own first-pixel-of-line, last-pixel-of-line and last-pixel-of-frame markers. The rest of the capture path needs no other framing.

Window and sensor sizes are written as the size minus one. In a size word the width occupies the low half and the height occupies the high half. All settings are copied into shadow registers while frame-valid is low, so a frame is always cropped with one consistent set of settings. If the window reaches past the programmed sensor frame, the output is clipped at the sensor edge and a sticky overflow flag is raised. For input that alternates fields, the sensor height is programmed as twice the height of one field.

Top module: `win_crop`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `out_valid`, `out_sol`, `out_eol`, `out_eof` and `ovf_flag` are all 0.
- R2: A pixel passes only if it is sampled with `in_fv` and `in_lv` high and its column x and line y (both counted from 0) satisfy `cfg_hoff` ≤ x ≤ `cfg_hoff`+width-1 and `cfg_voff` ≤ y ≤ `cfg_voff`+height-1. It appears one clock later on `out_data`, unchanged, with `out_valid` high.
- R3: In `cfg_win_size` and `cfg_sens_size`, bits [15:0] hold width-1 and bits [31:16] hold height-1. `cfg_hoff` is 13 bits wide and `cfg_voff` is 12 bits wide.
- R4: When `cfg_hdown` is 1, only columns where (x - `cfg_hoff`) is even pass. The first column of the window is always kept.
- R5: When `cfg_vdown` is 1, only lines where (y - `cfg_voff`) is even pass. This combines freely with R4.
- R6: `out_sol` is high with the first passed pixel of every output line. `out_eol` is high with the last passed pixel of that line.
- R7: `out_eof` is high, together with `out_eol`, only on the last passed pixel of the frame.
- R8: Pixels with x greater than sensor width-1, or y greater than sensor height-1, never pass. The R6 and R7 markers then land on the last pixel or line that passes inside the sensor frame.
- R9: `ovf_flag` becomes 1 when a frame starts with a window that extends past the sensor frame in either axis. It stays 1 until reset.
- R10: Settings are taken only while `in_fv` is low. Changes made during a frame take effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_fv | input | 1 | Frame valid |
| in_lv | input | 1 | Line valid, high only inside `in_fv` |
| in_data | input | DATA_W | Pixel value |
| cfg_sens_size | input | 32 | Sensor size, height-1 in [31:16], width-1 in [15:0] |
| cfg_win_size | input | 32 | Window size, same layout |
| cfg_hoff | input | 13 | Window left offset |
| cfg_voff | input | 12 | Window top offset |
| cfg_hdown | input | 1 | Keep every other column |
| cfg_vdown | input | 1 | Keep every other line |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | DATA_W | Output pixel |
| out_sol | output | 1 | First pixel of an output line |
| out_eol | output | 1 | Last pixel of an output line |
| out_eof | output | 1 | Last pixel of the frame |
| ovf_flag | output | 1 | Sticky window-overflow flag |

## Verification
Faults in the column or line counters show up at the ports within one line. They appear as a window shifted by one column, or as an `out_sol`/`out_eol` pair on the wrong pixel. The bench drives ramp data that encodes each pixel's own coordinates, so every passed pixel shows exactly where it came from. A wrong downsizing phase or a wrong clipping bound changes which coordinates come out, or moves the end markers, by the end of the first affected line. A shadow that follows the live settings is caught in the frame whose settings change midway, because the second half of that frame is cropped differently. A flag that is not sticky is caught by the check after the next clean frame.

// File: rtl/wincrop_pkg.sv
// Shared widths and the settings record used by the window cropper.
// Assumes the size words keep width-1 in the low half, height-1 in the high half.
package wincrop_pkg;
    localparam int SIZE_W  = 16;          // width-1 / height-1 field width
    localparam int HOFF_W  = 13;          // left offset field width
    localparam int VOFF_W  = 12;          // top offset field width
    localparam int SIZE_HI = SIZE_W;      // lsb of the height field
    localparam int POS_W   = SIZE_W + 1;  // coordinate and end-point width

    typedef struct packed {
        logic [HOFF_W-1:0] hoff;
        logic [VOFF_W-1:0] voff;
        logic [SIZE_W-1:0] wlast;   // window width-1
        logic [SIZE_W-1:0] hlast;   // window height-1
        logic [SIZE_W-1:0] swlast;  // sensor width-1
        logic [SIZE_W-1:0] shlast;  // sensor height-1
        logic              hdown;
        logic              vdown;
    } win_cfg_t;
endpackage

// File: rtl/win_shadow.sv
// Holds the settings used for the current frame.
// Loads every cycle while frame-valid is low and freezes while it is high.
// Also flags the first cycle of a frame.
module win_shadow
    import wincrop_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fv,
    input  win_cfg_t live_cfg,
    output win_cfg_t shd_cfg,
    output logic     frame_start
);
    logic fv_q;

    // Track frame-valid one cycle back to detect the frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) fv_q <= 1'b0;
        else        fv_q <= fv;
    end

    // Follow the live settings between frames, hold them inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)   shd_cfg <= '0;
        else if (!fv) shd_cfg <= live_cfg;
    end

    assign frame_start = fv & ~fv_q;
endmodule

// File: rtl/pos_count.sv
// Column and line counters of the incoming frame.
// x is the index of the pixel now on the input while line-valid is high.
// y is the index of the current line.
// Assumes line-valid drops for at least one cycle between lines.
module pos_count #(
    parameter int X_W = 17,
    parameter int Y_W = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fv,
    input  logic           lv,
    output logic [X_W-1:0] x,
    output logic [Y_W-1:0] y
);
    localparam logic [X_W-1:0] X_MAX = '1;
    localparam logic [Y_W-1:0] Y_MAX = '1;
    logic lv_q;

    // Count accepted pixels within a line; restart when the line ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !lv) x <= '0;
        else if (x != X_MAX) x <= x + 1'b1;
    end

    // Delay line-valid to find the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= 1'b0;
        else        lv_q <= lv;
    end

    // Count finished lines within a frame; restart between frames.
    always_ff @(posedge clk) begin
        if (!rst_n || !fv) y <= '0;
        else if (lv_q && !lv && y != Y_MAX) y <= y + 1'b1;
    end
endmodule

// File: rtl/win_axis.sv
// Window test for one axis, purely combinational.
// Gives whether a position is kept, whether it is the first or the last kept
// position, and whether the window runs past the sensor limit.
// Assumes OFF_W and SZ_W are both below POS_W.
module win_axis #(
    parameter int OFF_W = 13,
    parameter int SZ_W  = 16,
    parameter int POS_W = 17
) (
    input  logic [OFF_W-1:0] off,
    input  logic [SZ_W-1:0]  last,
    input  logic [SZ_W-1:0]  lim,
    input  logic             down,
    input  logic [POS_W-1:0] pos,
    output logic             keep,
    output logic             first,
    output logic             final_pos,
    output logic             overrun
);
    logic [POS_W-1:0] off_e, wend, lim_e, span_end, keep_end;
    logic             odd_rel, odd_span;

    // Window end, clipped to the sensor edge, then pulled back to an even step.
    always_comb begin
        off_e    = POS_W'(off);
        lim_e    = POS_W'(lim);
        wend     = off_e + POS_W'(last);
        overrun  = wend > lim_e;
        span_end = overrun ? lim_e : wend;
        odd_span = span_end[0] ^ off_e[0];
        keep_end = (down && odd_span) ? span_end - 1'b1 : span_end;
    end

    // Classify the current position against the window.
    always_comb begin
        odd_rel   = pos[0] ^ off_e[0];
        keep      = (pos >= off_e) && (pos <= span_end) && !(down && odd_rel);
        first     = pos == off_e;
        final_pos = pos == keep_end;
    end
endmodule

// File: rtl/win_crop.sv
// Capture window cropper: forwards the programmed rectangle of each frame,
// optionally halved per axis, with line and frame markers and one clock latency.
// Assumes in_lv is high only inside in_fv and that the settings are stable
// in the cycle before in_fv rises.
module win_crop
    import wincrop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_fv,
    input  logic              in_lv,
    input  logic [DATA_W-1:0] in_data,
    input  logic [31:0]       cfg_sens_size,
    input  logic [31:0]       cfg_win_size,
    input  logic [12:0]       cfg_hoff,
    input  logic [11:0]       cfg_voff,
    input  logic              cfg_hdown,
    input  logic              cfg_vdown,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_eol,
    output logic              out_eof,
    output logic              ovf_flag
);
    win_cfg_t         live_cfg, shd_cfg;
    logic             frame_start, pix;
    logic [POS_W-1:0] px, py;
    logic             kx, fx, lx, ox, ky, fy, ly, oy, pass;

    // Unpack the size words into the settings record.
    always_comb begin
        live_cfg.hoff   = cfg_hoff;
        live_cfg.voff   = cfg_voff;
        live_cfg.wlast  = cfg_win_size[SIZE_W-1:0];
        live_cfg.hlast  = cfg_win_size[SIZE_HI +: SIZE_W];
        live_cfg.swlast = cfg_sens_size[SIZE_W-1:0];
        live_cfg.shlast = cfg_sens_size[SIZE_HI +: SIZE_W];
        live_cfg.hdown  = cfg_hdown;
        live_cfg.vdown  = cfg_vdown;
    end

    win_shadow u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .fv          (in_fv),
        .live_cfg    (live_cfg),
        .shd_cfg     (shd_cfg),
        .frame_start (frame_start)
    );

    pos_count #(.X_W(POS_W), .Y_W(POS_W)) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .fv    (in_fv),
        .lv    (in_lv),
        .x     (px),
        .y     (py)
    );

    win_axis #(.OFF_W(HOFF_W), .SZ_W(SIZE_W), .POS_W(POS_W)) u_hax (
        .off       (shd_cfg.hoff),
        .last      (shd_cfg.wlast),
        .lim       (shd_cfg.swlast),
        .down      (shd_cfg.hdown),
        .pos       (px),
        .keep      (kx),
        .first     (fx),
        .final_pos (lx),
        .overrun   (ox)
    );

    win_axis #(.OFF_W(VOFF_W), .SZ_W(SIZE_W), .POS_W(POS_W)) u_vax (
        .off       (shd_cfg.voff),
        .last      (shd_cfg.hlast),
        .lim       (shd_cfg.shlast),
        .down      (shd_cfg.vdown),
        .pos       (py),
        .keep      (ky),
        .first     (fy),
        .final_pos (ly),
        .overrun   (oy)
    );

    assign pix  = in_fv & in_lv;
    assign pass = pix & kx & ky;

    // Register the kept pixel and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
            out_eof   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pass;
            out_sol   <= pass & fx;
            out_eol   <= pass & lx;
            out_eof   <= pass & lx & ly;
            if (pix) out_data <= in_data;
        end
    end

    // Raise the sticky flag when a frame opens with an oversized window.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_flag <= 1'b0;
        else if (frame_start && (ox || oy)) ovf_flag <= 1'b1;
    end
endmodule

// File: rtl/win_crop_chk.sv
// Property checker for the window cropper, attached by bind.
module win_crop_chk
    import wincrop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_fv,
    input logic              in_lv,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_sol,
    input logic              out_eol,
    input logic              out_eof,
    input logic              ovf_flag,
    input win_cfg_t          shd_cfg
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_sol && !out_eol && !out_eof && !ovf_flag));

    // R2
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(in_fv && in_lv) && out_data == $past(in_data)));

    // R4
    hdec_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && shd_cfg.hdown && in_fv) |=> !out_valid);

    // R6
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sol || out_eol || out_eof) |-> out_valid);

    // R7
    eof_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> out_eol);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R10
    shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fv && $past(in_fv)) |-> $stable(shd_cfg));
endmodule

bind win_crop win_crop_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fv     (in_fv),
    .in_lv     (in_lv),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sol   (out_sol),
    .out_eol   (out_eol),
    .out_eof   (out_eof),
    .ovf_flag  (ovf_flag),
    .shd_cfg   (shd_cfg)
);

// File: tb/win_crop_test.sv
// Bench for the window cropper: table-driven ramp frames, then directed cases.
module win_crop_test;
    localparam int DW = 16;

    typedef struct packed {
        logic [12:0] hoff;
        logic [11:0] voff;
        logic [15:0] w1;
        logic [15:0] h1;
        logic [15:0] sw1;
        logic [15:0] sh1;
        logic        hd;
        logic        vd;
        logic [7:0]  dw;
        logic [7:0]  dh;
    } tcase_t;

    typedef struct packed {
        logic          v;
        logic          sol;
        logic          eol;
        logic          eof;
        logic [DW-1:0] d;
    } exp_t;

    localparam int NCASE = 6;
    localparam tcase_t CASES [NCASE] = '{
        '{13'd3, 12'd2, 16'd4,  16'd2, 16'd11, 16'd7, 1'b0, 1'b0, 8'd12, 8'd8}, // R2 R3
        '{13'd2, 12'd1, 16'd6,  16'd3, 16'd11, 16'd7, 1'b1, 1'b0, 8'd12, 8'd8}, // R4 even span
        '{13'd1, 12'd0, 16'd5,  16'd1, 16'd11, 16'd7, 1'b1, 1'b0, 8'd12, 8'd8}, // R4 odd span
        '{13'd2, 12'd1, 16'd3,  16'd4, 16'd11, 16'd7, 1'b0, 1'b1, 8'd12, 8'd8}, // R5
        '{13'd0, 12'd0, 16'd11, 16'd7, 16'd11, 16'd7, 1'b1, 1'b1, 8'd12, 8'd8}, // R6 R7
        '{13'd8, 12'd5, 16'd7,  16'd5, 16'd11, 16'd7, 1'b0, 1'b0, 8'd14, 8'd9}  // R8 R9
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_fv = 1'b0, in_lv = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [31:0]   cfg_sens_size = '0, cfg_win_size = '0;
    logic [12:0]   cfg_hoff = '0;
    logic [11:0]   cfg_voff = '0;
    logic          cfg_hdown = 1'b0, cfg_vdown = 1'b0;
    logic          out_valid, out_sol, out_eol, out_eof, ovf_flag;
    logic [DW-1:0] out_data;

    int   n_chk = 0, n_bad = 0, cyc = 0;
    exp_t pend = '0;
    logic ovf_exp = 1'b0;

    always #5 clk = ~clk;

    win_crop #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_fv(in_fv), .in_lv(in_lv), .in_data(in_data),
        .cfg_sens_size(cfg_sens_size), .cfg_win_size(cfg_win_size),
        .cfg_hoff(cfg_hoff), .cfg_voff(cfg_voff),
        .cfg_hdown(cfg_hdown), .cfg_vdown(cfg_vdown),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol),
        .out_eol(out_eol), .out_eof(out_eof), .ovf_flag(ovf_flag)
    );

    // Watchdog: a hung run is reported as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic bit keep_x(tcase_t c, int x);
        return x >= int'(c.hoff) && x <= int'(c.hoff) + int'(c.w1) && x <= int'(c.sw1)
               && (!c.hd || ((x - int'(c.hoff)) % 2 == 0));
    endfunction

    function automatic bit keep_y(tcase_t c, int y);
        return y >= int'(c.voff) && y <= int'(c.voff) + int'(c.h1) && y <= int'(c.sh1)
               && (!c.vd || ((y - int'(c.voff)) % 2 == 0));
    endfunction

    task automatic check1(string tag, logic act, logic expv, string what);
        n_chk = n_chk + 1;
        if (act !== expv) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
        end
    endtask

    // One cycle: compare the outputs for the previous input, then drive the next.
    task automatic step(string tag, logic fv, logic lv, logic [DW-1:0] d, exp_t e);
        @(negedge clk);
        n_chk = n_chk + 1;
        if (out_valid !== pend.v || out_sol !== pend.sol || out_eol !== pend.eol ||
            out_eof !== pend.eof || (pend.v && out_data !== pend.d)) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual v%0b s%0b e%0b f%0b d%h expected v%0b s%0b e%0b f%0b d%h",
                     tag, out_valid, out_sol, out_eol, out_eof, out_data,
                     pend.v, pend.sol, pend.eol, pend.eof, pend.d);
        end
        in_fv = fv; in_lv = lv; in_data = d;
        pend = e;
    endtask

    task automatic put_cfg(tcase_t c);
        cfg_hoff      = c.hoff;
        cfg_voff      = c.voff;
        cfg_win_size  = {c.h1, c.w1};
        cfg_sens_size = {c.sh1, c.sw1};
        cfg_hdown     = c.hd;
        cfg_vdown     = c.vd;
    endtask

    // Drive one ramp frame; data is {line, column} so each output names its origin.
    task automatic run_frame(tcase_t c, bit mid_change, tcase_t alt, string tag);
        int lastx = -1, lasty = -1;
        exp_t e;
        @(negedge clk);
        put_cfg(c);
        step(tag, 1'b0, 1'b0, '0, '0);
        step(tag, 1'b0, 1'b0, '0, '0);
        for (int i = 0; i < 512; i++) begin
            if (keep_x(c, i)) lastx = i;
            if (keep_y(c, i)) lasty = i;
        end
        step(tag, 1'b1, 1'b0, '0, '0);
        for (int yy = 0; yy < int'(c.dh); yy++) begin
            for (int xx = 0; xx < int'(c.dw); xx++) begin
                e.v   = keep_x(c, xx) && keep_y(c, yy);
                e.sol = e.v && xx == int'(c.hoff);
                e.eol = e.v && xx == lastx;
                e.eof = e.eol && yy == lasty;
                e.d   = {yy[7:0], xx[7:0]};
                step(tag, 1'b1, 1'b1, {yy[7:0], xx[7:0]}, e);
            end
            if (mid_change && yy == 0) put_cfg(alt);  // R10: must not touch this frame
            step(tag, 1'b1, 1'b0, '0, '0);
            step(tag, 1'b1, 1'b0, '0, '0);
        end
        step(tag, 1'b0, 1'b0, '0, '0);
        step(tag, 1'b0, 1'b0, '0, '0);
        if (int'(c.hoff) + int'(c.w1) > int'(c.sw1) || int'(c.voff) + int'(c.h1) > int'(c.sh1))
            ovf_exp = 1'b1;
        check1("R9", ovf_flag, ovf_exp, "ovf_flag after frame");
    endtask

    function automatic string tag_of(int i);
        case (i)
            0: return "R2";
            1: return "R4";
            2: return "R4";
            3: return "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        tcase_t alt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check1("R1", out_valid, 1'b0, "out_valid in reset");
        check1("R1", ovf_flag, 1'b0, "ovf_flag in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", out_eof | out_sol | out_eol, 1'b0, "markers after reset");

        // Table of frames, walked by one loop (R2 R3 R4 R5 R6 R7 R8 R9).
        for (int i = 0; i < NCASE; i++) run_frame(CASES[i], 1'b0, CASES[i], tag_of(i));

        // R10: settings changed after the first line must wait for the next frame.
        alt = CASES[1];
        run_frame(CASES[0], 1'b1, alt, "R10");
        run_frame(alt, 1'b0, alt, "R10");

        // R9: flag stays set across clean frames.
        check1("R9", ovf_flag, 1'b1, "sticky ovf_flag");

        // R1: reset clears the sticky flag.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pend = '0;
        ovf_exp = 1'b0;
        @(negedge clk);
        check1("R1", ovf_flag, 1'b0, "ovf_flag after second reset");
        check1("R1", out_valid, 1'b0, "out_valid after second reset");

        // R6: single-column window, first and last marker on one pixel.
        alt = '{13'd5, 12'd3, 16'd0, 16'd0, 16'd11, 16'd7, 1'b1, 1'b1, 8'd12, 8'd8};
        run_frame(alt, 1'b0, alt, "R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule